// File: doc/BRIEF.md
# Sample Clock Phase Tuning Engine

This block finds a good sampling point for a card interface whose receive clock phase can be moved in discrete steps around the full 360-degree circle. After a start pulse it steps through candidate phase indices. For each one it presents the phase in degrees and requests one tuning trial from an external agent, then takes the pass/fail answer. Every trial result is folded into a small table of contiguous passing windows. Once the sweep is over, the engine joins a window that crosses from the last step back to step 0, finds the widest window and reports its centre in degrees.

Testing a bad phase is slow, so a failing result makes the sweep jump ahead by about 20 degrees instead of one step. The last step is always tried. When every step passes there is no meaningful centre, so a configured default phase is reported instead. When no step passes, an error flag is raised. The result comes with a one-cycle done pulse, and the engine then waits in idle for the next start.

Top module: `phase_tune_engine`

## Requirements
- R1: A start pulse in idle begins a sweep whose first trial is at step 0 (0 degrees). A start pulse during a sweep has no effect on the trials or the result.
- R2: During a trial at step i, `phase_deg` equals ceil(i*360/NSTEPS) and holds steady while `trial_req` is high. `trial_done`/`trial_pass` are consumed only while `trial_req` is high, and `trial_pass`=1 means the step passed.
- R3: After a passing trial at step i < NSTEPS-1 the next trial is at step i+1. A pass that follows a fail (or is the first pass of the sweep) opens a new window, and each pass moves the inclusive end of the open window. At most NSTEPS/2+1 windows are held.
- R4: After a failing trial at step i < NSTEPS-1 the next trial is at i+ceil(20*NSTEPS/360), clamped to NSTEPS-1. Any trial at step NSTEPS-1 ends the sweep.
- R5: If more than one window exists and both step 0 and the final tested step passed, the last window is joined to the first. The first window then starts where the last one started, and the last window is dropped.
- R6: If no trial passes, `tune_err` is high with `tune_done`, and `phase_deg` keeps the last trial's phase, ceil((NSTEPS-1)*360/NSTEPS).
- R7: If the first window spans step 0 to step NSTEPS-1, the result is DEFAULT_DEG.
- R8: Window length is end-start+1, plus NSTEPS when that is negative. The longest window is chosen, and on a tie the earliest window in the table wins.
- R9: The reported phase is ceil(c*360/NSTEPS) degrees, where c = (start + length/2) mod NSTEPS and the division truncates.
- R10: `tune_done` is a one-cycle pulse carrying the result on `phase_deg`, with `tune_err` low on success. `trial_req` is low while `tune_done` is high and while idle.
- R11: Synchronous reset clears `trial_req`, `tune_done`, `tune_err` and `phase_deg` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (accepted in idle only) |
| trial_req | output | 1 | A trial at the presented phase is requested |
| trial_done | input | 1 | One-cycle pulse: trial finished |
| trial_pass | input | 1 | Result qualifying trial_done, 1 = pass |
| phase_deg | output | 9 | Current trial phase, then the tuned phase, in degrees |
| tune_done | output | 1 | One-cycle pulse: result valid |
| tune_err | output | 1 | No passing phase found |

## Verification
The assertions watch the properties that hold on every cycle: the presented phase stays stable across a trial request, the done pulse lasts one cycle and never overlaps a request, the error flag only rises together with done, and the window table never exceeds its capacity. The choice of trial steps, the skip and clamp rule, the wrap-around join, the widest-window and tie rules, the default for an all-pass sweep and the degree conversion can only be shown by the bench's scenarios. Those scenarios cover every single passing window at every start and length on a 20-step circle, plus mixed and random patterns. For each one, an arithmetic model in the bench predicts the trial sequence and the result.

// File: rtl/phase_tune_pkg.sv
package phase_tune_pkg;

    localparam int DEG_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRIAL,
        ST_NEXT,
        ST_MERGE,
        ST_CHECK,
        ST_SCAN,
        ST_PICK
    } tune_state_e;

    typedef struct packed {
        logic prev_pass;
        logic first_pass;
        logic last_pass;
    } sweep_flags_t;

    // ceil(step*360/nsteps)
    function automatic logic [DEG_W-1:0] step_to_deg(input int unsigned step,
                                                     input int unsigned nsteps);
        int unsigned t;
        t = (step * 360 + nsteps - 1) / nsteps;
        return t[DEG_W-1:0];
    endfunction

    // steps covering about 20 degrees, rounded up
    function automatic int unsigned skip_steps(input int unsigned nsteps);
        return (20 * nsteps + 359) / 360;
    endfunction

endpackage

// File: rtl/pt_range_store.sv
module pt_range_store #(
    parameter int DEPTH = 181,
    parameter int IW    = 9,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          open_en,
    input  logic          ext_en,
    input  logic          merge_en,
    input  logic [IW-1:0] idx,
    input  logic [CW-1:0] rd_addr,
    output logic [CW-1:0] count,
    output logic [IW-1:0] rd_start,
    output logic [IW-1:0] rd_end
);
    logic [IW-1:0] lo_mem [DEPTH];
    logic [IW-1:0] hi_mem [DEPTH];
    logic          room;

    assign room = (32'(count) < DEPTH);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (open_en && room) begin
            count <= count + 1'b1;
        end else if (merge_en) begin
            count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (open_en && room) begin
            lo_mem[count] <= idx;
            hi_mem[count] <= idx;
        end else if (ext_en) begin
            hi_mem[count - 1'b1] <= idx;
        end else if (merge_en) begin
            lo_mem[0] <= lo_mem[count - 1'b1];
        end
    end

    assign rd_start = lo_mem[rd_addr];
    assign rd_end   = hi_mem[rd_addr];

endmodule

// File: rtl/pt_best_range.sv
module pt_best_range #(
    parameter int NSTEPS = 360,
    parameter int IW     = 9,
    parameter int LW     = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init,
    input  logic          en,
    input  logic [IW-1:0] cand_start,
    input  logic [IW-1:0] cand_end,
    output logic [IW-1:0] best_start,
    output logic [LW-1:0] best_len
);
    localparam logic signed [IW+1:0] ONE  = (IW+2)'(1);
    localparam logic signed [IW+1:0] NSGN = (IW+2)'(NSTEPS);

    logic signed [IW+1:0] diff;
    logic signed [IW+1:0] adj;
    logic [LW-1:0]        cand_len;
    logic                 have;

    always_comb begin
        diff     = $signed({2'b00, cand_end}) - $signed({2'b00, cand_start}) + ONE;
        adj      = diff[IW+1] ? diff + NSGN : diff;
        cand_len = adj[LW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || init) begin
            have       <= 1'b0;
            best_start <= '0;
            best_len   <= '0;
        end else if (en && (!have || cand_len > best_len)) begin
            have       <= 1'b1;
            best_start <= cand_start;
            best_len   <= cand_len;
        end
    end

endmodule

// File: rtl/phase_tune_engine.sv
module phase_tune_engine
    import phase_tune_pkg::*;
#(
    parameter int NSTEPS      = 360,
    parameter int DEFAULT_DEG = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             trial_req,
    input  logic             trial_done,
    input  logic             trial_pass,
    output logic [DEG_W-1:0] phase_deg,
    output logic             tune_done,
    output logic             tune_err
);
    localparam int IW    = (NSTEPS > 1) ? $clog2(NSTEPS) : 1;
    localparam int DEPTH = NSTEPS / 2 + 1;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int LW    = IW + 1;
    localparam int SKIP  = skip_steps(NSTEPS);
    localparam logic [IW-1:0] LAST = IW'(NSTEPS - 1);

    tune_state_e      state;
    logic [IW-1:0]    idx;
    sweep_flags_t     flg;
    logic [CW-1:0]    scan_i;
    logic [DEG_W-1:0] phase_q;
    logic             done_q;
    logic             err_q;

    logic [CW-1:0]    rng_count;
    logic [CW-1:0]    rd_addr;
    logic [IW-1:0]    rd_start, rd_end;
    logic [IW-1:0]    best_start;
    logic [LW-1:0]    best_len;

    logic             trial_ok, open_en, ext_en, merge_en, clr;
    logic [IW:0]      skip_to;
    logic [IW-1:0]    nxt;
    logic [IW:0]      pick_sum;
    logic [IW:0]      pick_step;
    logic             all_pass;

    assign trial_ok = (state == ST_TRIAL) && trial_done;
    assign open_en  = trial_ok && trial_pass && !flg.prev_pass;
    assign ext_en   = trial_ok && trial_pass && flg.prev_pass;
    assign merge_en = (state == ST_MERGE) && (rng_count > CW'(1))
                      && flg.first_pass && flg.last_pass;
    assign clr      = (state == ST_IDLE) && start;
    assign rd_addr  = (state == ST_SCAN) ? scan_i : '0;
    assign all_pass = (rd_start == '0) && (rd_end == LAST);

    // next step index: +1 after a pass, skip ahead (clamped) after a fail
    always_comb begin
        skip_to = {1'b0, idx} + (IW+1)'(SKIP);
        if (trial_pass)
            nxt = idx + 1'b1;
        else if (skip_to >= (IW+1)'(NSTEPS - 1))
            nxt = LAST;
        else
            nxt = skip_to[IW-1:0];
    end

    // centre of the widest window, wrapped onto the circle
    always_comb begin
        pick_sum  = {1'b0, best_start} + (best_len >> 1);
        pick_step = (pick_sum >= (IW+1)'(NSTEPS)) ? pick_sum - (IW+1)'(NSTEPS) : pick_sum;
    end

    pt_range_store #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .open_en  (open_en),
        .ext_en   (ext_en),
        .merge_en (merge_en),
        .idx      (idx),
        .rd_addr  (rd_addr),
        .count    (rng_count),
        .rd_start (rd_start),
        .rd_end   (rd_end)
    );

    pt_best_range #(.NSTEPS(NSTEPS), .IW(IW), .LW(LW)) u_best (
        .clk        (clk),
        .rst        (rst),
        .init       (state == ST_CHECK),
        .en         (state == ST_SCAN),
        .cand_start (rd_start),
        .cand_end   (rd_end),
        .best_start (best_start),
        .best_len   (best_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            idx     <= '0;
            flg     <= '0;
            scan_i  <= '0;
            phase_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        idx     <= '0;
                        flg     <= '0;
                        phase_q <= step_to_deg(0, NSTEPS);
                        err_q   <= 1'b0;
                        state   <= ST_TRIAL;
                    end
                end
                ST_TRIAL: begin
                    if (trial_done) begin
                        flg.prev_pass <= trial_pass;
                        flg.last_pass <= trial_pass;
                        if (idx == '0)
                            flg.first_pass <= trial_pass;
                        if (idx == LAST) begin
                            state <= ST_MERGE;
                        end else begin
                            idx     <= nxt;
                            phase_q <= step_to_deg(32'(nxt), NSTEPS);
                            state   <= ST_NEXT;
                        end
                    end
                end
                ST_NEXT: state <= ST_TRIAL;
                ST_MERGE: begin
                    if (rng_count == '0) begin
                        err_q  <= 1'b1;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (all_pass) begin
                        phase_q <= DEG_W'(DEFAULT_DEG);
                        done_q  <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        scan_i <= '0;
                        state  <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (scan_i == rng_count - 1'b1)
                        state <= ST_PICK;
                    else
                        scan_i <= scan_i + 1'b1;
                end
                ST_PICK: begin
                    phase_q <= step_to_deg(32'(pick_step), NSTEPS);
                    done_q  <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign trial_req = (state == ST_TRIAL);
    assign phase_deg = phase_q;
    assign tune_done = done_q;
    assign tune_err  = err_q;

endmodule

// File: rtl/phase_tune_chk.sv
module phase_tune_chk #(
    parameter int NSTEPS = 360,
    parameter int DEG_W  = 9
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          trial_req,
    input logic [DEG_W-1:0]              phase_deg,
    input logic                          tune_done,
    input logic                          tune_err,
    input logic [$clog2(NSTEPS/2+2)-1:0] rng_count
);
    localparam int DEPTH = NSTEPS / 2 + 1;

    // R3: window table never holds more than its capacity
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        32'(rng_count) <= DEPTH);

    // R2: presented phase is steady for the whole trial request
    p_phase_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (trial_req && $past(trial_req)) |-> $stable(phase_deg));

    // R10: done lasts exactly one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        tune_done |=> !tune_done);

    // R10: no trial is requested while the result is reported
    p_done_no_req_r10: assert property (@(posedge clk) disable iff (rst)
        tune_done |-> !trial_req);

    // R6: error flag only appears together with done
    p_err_at_done_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(tune_err) |-> tune_done);

endmodule

bind phase_tune_engine phase_tune_chk #(.NSTEPS(NSTEPS), .DEG_W(9)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .trial_req (trial_req),
    .phase_deg (phase_deg),
    .tune_done (tune_done),
    .tune_err  (tune_err),
    .rng_count (rng_count)
);

// File: tb/sim_phase_tune_engine.sv
`timescale 1ns/1ps
module sim_phase_tune_engine;

    localparam int N    = 20;
    localparam int DEF  = 45;
    localparam int SKIP = (20 * N + 359) / 360;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       trial_done = 1'b0;
    logic       trial_pass = 1'b0;
    logic       trial_req;
    logic [8:0] phase_deg;
    logic       tune_done;
    logic       tune_err;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    phase_tune_engine #(.NSTEPS(N), .DEFAULT_DEG(DEF)) u0 (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .trial_req  (trial_req),
        .trial_done (trial_done),
        .trial_pass (trial_pass),
        .phase_deg  (phase_deg),
        .tune_done  (tune_done),
        .tune_err   (tune_err)
    );

    // expected results
    int    e_seq [32];
    int    e_ntr;
    bit    e_err;
    int    e_deg;
    string e_tag;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int deg(input int i);
        return (i * 360 + N - 1) / N;
    endfunction

    task automatic model(input logic [N-1:0] pat);
        int rs [N];
        int re [N];
        int i, k, rc, bl, bi, len, mid;
        bit v, prev, first, merged;
        i = 0; k = 0; rc = 0; prev = 0; first = 0; v = 0; merged = 0;
        while (i < N) begin
            e_seq[k] = i; k++;
            v = pat[i];
            if (i == 0) first = v;
            if (!prev && v) begin rc++; rs[rc-1] = i; end
            if (v) begin
                re[rc-1] = i; i++;
            end else if (i == N - 1) begin
                i++;
            end else begin
                i += SKIP;
                if (i >= N) i = N - 1;
            end
            prev = v;
        end
        e_ntr = k;
        e_err = (rc == 0);
        if (rc == 0) begin
            e_deg = deg(N - 1);
            e_tag = "R6 no pass";
        end else begin
            if (rc > 1 && first && v) begin
                rs[0] = rs[rc-1]; rc--; merged = 1;
            end
            if (rs[0] == 0 && re[0] == N - 1) begin
                e_deg = DEF;
                e_tag = "R7 all pass";
            end else begin
                bl = -1; bi = 0;
                for (int j = 0; j < rc; j++) begin
                    len = re[j] - rs[j] + 1;
                    if (len < 0) len += N;
                    if (bl < len) begin bl = len; bi = j; end
                end
                mid   = (rs[bi] + bl / 2) % N;
                e_deg = deg(mid);
                e_tag = merged ? "R5 R8 R9 wrapped" : "R8 R9 centre";
            end
        end
    endtask

    task automatic run_case(input logic [N-1:0] pat, input bit inject, input string pre);
        int k, idx, lat, t0;
        bit fin;
        model(pat);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        k = 0; t0 = cyc; fin = 0;
        while (!fin && (cyc - t0) < 3000) begin
            if (tune_done) begin
                fin = 1;
            end else if (trial_req) begin
                idx = (k < e_ntr) ? e_seq[k] : N - 1;
                chk((int'(phase_deg) == deg(idx)) && (k < e_ntr),
                    {pre, "R2 R3 R4 trial phase"}, int'(phase_deg), deg(idx));
                lat = 1 + (k % 3);
                for (int w = 0; w < lat; w++) begin
                    if (inject && k == 2 && w == 0) start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
                trial_done = 1'b1;
                trial_pass = pat[idx];
                @(negedge clk);
                trial_done = 1'b0;
                trial_pass = 1'b0;
                k++;
            end else begin
                @(negedge clk);
            end
        end
        if (!fin) begin
            chk(1'b0, {pre, "R10 no done"}, 0, 1);
        end else begin
            chk(k == e_ntr, {pre, "R4 trial count"}, k, e_ntr);
            chk(tune_err == e_err, {pre, e_tag, " err"}, int'(tune_err), int'(e_err));
            chk(int'(phase_deg) == e_deg, {pre, e_tag, " phase"}, int'(phase_deg), e_deg);
            @(negedge clk);
            chk(!tune_done, {pre, "R10 done pulse"}, int'(tune_done), 0);
            chk(!trial_req, {pre, "R10 idle req"}, int'(trial_req), 0);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 190000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] lf;
        logic [31:0] a, b;
        logic [N-1:0] pat;
        lf = 32'hACE1_2345;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!trial_req, "R11 reset trial_req", int'(trial_req), 0);
        chk(!tune_done, "R11 reset tune_done", int'(tune_done), 0);
        chk(!tune_err,  "R11 reset tune_err", int'(tune_err), 0);
        chk(phase_deg == 9'd0, "R11 reset phase", int'(phase_deg), 0);
        rst = 1'b0;
        @(negedge clk);

        // directed
        run_case({N{1'b1}}, 1'b0, "");                 // R7
        run_case({N{1'b0}}, 1'b0, "");                 // R6
        run_case(20'b1110_0000_0000_0000_0111, 1'b0, ""); // R5 wrap
        run_case(20'b0000_1110_0000_0111_0000, 1'b0, ""); // R8 tie
        run_case(20'b1000_0000_0000_0000_0001, 1'b0, ""); // R5 two ends
        run_case(20'b0110_0000_0000_0000_0000, 1'b1, "R1 start ignored ");
        run_case(20'b1010_1011_1101_0111_0110, 1'b1, "R1 start ignored ");

        // every single window on the circle (with wrap)
        for (int s = 0; s < N; s++) begin
            for (int l = 1; l <= N; l++) begin
                pat = '0;
                for (int j = 0; j < l; j++) pat[(s + j) % N] = 1'b1;
                run_case(pat, 1'b0, "");
            end
        end

        // mixed random patterns
        for (int c = 0; c < 400; c++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            a  = lf * 32'd2654435761;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            b  = lf ^ (lf >> 7);
            case (c % 3)
                0:       pat = a[N-1:0] & b[N-1:0];
                1:       pat = a[N-1:0] | b[N-1:0];
                default: pat = a[N-1:0];
            endcase
            run_case(pat, (c % 37) == 5, "");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule